// File: doc/BRIEF.md
# Sixteen-Port I/O Command Controller

This block is the input/output section of a memory and I/O device sitting on a shared processor bus. Earlier in each bus cycle the processor puts a RAM-style address on the bus. The block latches the low four bits of that address as the number of the port to work on. When the processor runs an I/O instruction, the following instruction byte arrives on `cmd_byte` together with `cmd_valid`. The upper nibble of that byte names the target device and the lower nibble holds the command. The block acts only when the whole device nibble equals its strap parameter `DEV_ID`. Legal strap values are 0, 2, 4 and 6.

Two commands exist, and command bit 0 picks between them. With bit 0 low, the accumulator bit `acc_bit` becomes the global drive enable for all sixteen ports. With bit 0 high, `acc_bit` is written into the one-bit latch of the port that was addressed. A pin is driven high only when both the global enable and its own latch are set. In every other case the pin floats and the outside level is sensed on `pin_in`. Each accepted command also returns the sensed level of the addressed port on a one-cycle response strobe.

The command and response interfaces are plain valid strobes with no ready signal. The block takes a command in any cycle and has no back-pressure. The response is produced unconditionally, and the receiver must take it in the cycle it is valid.

Top module: `io16_cmd_ctrl`

## Requirements
- R1: The command byte carries the device ID in bits 7..4 and the command in bits 3..0. Command bit 0 selects the operation: 0 is the enable command and 1 is the port command.
- R2: A command whose 4-bit ID differs from `DEV_ID` in any bit changes no enable or latch state and produces no response.
- R3: The port number is `addr_bus[3:0]`, captured on a cycle with `addr_load` high. `addr_bus[5:4]` have no effect. A command uses the most recently captured port number.
- R4: An enable command with a matching ID sets the global enable to `acc_bit`. This is visible on `pin_oe` from the cycle after `cmd_valid`.
- R5: A port command with a matching ID writes `acc_bit` into the latch of the captured port, visible on `pin_out` from the cycle after `cmd_valid`. All other latches keep their values.
- R6: `pin_out[i]` shows latch i, and `pin_oe[i]` is high exactly when the global enable and latch i are both 1.
- R7: While `rst_n` is low, the global enable, all sixteen latches and `rsp_valid` are cleared.
- R8: The cycle after a matching command, `rsp_valid` is high for exactly one cycle and `rsp_data` carries `pin_in` of the captured port, sampled in the `cmd_valid` cycle.
- R9: In cycles without `cmd_valid`, `pin_out` and `pin_oe` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Capture the port number from addr_bus |
| addr_bus | input | 6 | Address bits; only [3:0] are used |
| cmd_valid | input | 1 | The command byte is present |
| cmd_byte | input | 8 | [7:4] device ID, [3:0] command |
| acc_bit | input | 1 | Data bit for the enable or latch write |
| pin_in | input | 16 | Sensed pin levels |
| pin_out | output | 16 | Latched output value per port |
| pin_oe | output | 16 | Per-pin drive enable |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 1 | Sensed level of the addressed port |

## Verification
The port command is driven at the lowest port, the highest port and a port in the middle, with the global enable both off and on. This shows that each latch is reached only through its own address and that drive needs both conditions. Device IDs that differ from the strap in only the top bit, or only the bottom bit, show that all four ID bits are compared. Addresses with bits 5..4 set, and address loads overwritten before a command, show which address bits count and which capture is used. The response is checked with `pin_in` patterns that put opposite levels on the addressed port and its neighbours, so a wrong index shows up in `rsp_data`.

// File: rtl/io16_pkg.sv
package io16_pkg;
  localparam int ID_W = 4;
  localparam int OP_W = 4;

  typedef struct packed {
    logic [ID_W-1:0] dev;
    logic [OP_W-1:0] op;
  } iocmd_t;

  localparam int OP_SEL_BIT = 0;
endpackage

// File: rtl/io16_id_match.sv
module io16_id_match #(
  parameter int ID_W = 4,
  parameter logic [ID_W-1:0] DEV_ID = '0
) (
  input  logic            valid,
  input  logic [ID_W-1:0] id,
  output logic            hit
);
  always_comb hit = valid && (id == DEV_ID);
endmodule

// File: rtl/io16_port_bank.sv
module io16_port_bank #(
  parameter int NPORTS = 16,
  parameter int IDX_W  = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_we,
  input  logic              lat_we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wval,
  output logic [NPORTS-1:0] lat_q,
  output logic [NPORTS-1:0] drive_en
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       gate_q <= 1'b0;
    else if (gate_we) gate_q <= wval;
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n)                              lat_q[g] <= 1'b0;
      else if (lat_we && idx == IDX_W'(g))     lat_q[g] <= wval;
    end
    always_comb drive_en[g] = gate_q & lat_q[g];
  end

  // R5: written latch takes the written value
  a_r5_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we |=> lat_q[$past(idx)] == $past(wval));
  // R6: a pin is driven only where its latch is set
  a_r6_drive_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en & ~lat_q) == '0);
  // R4: enable write reaches every set latch
  a_r4_gate_write: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_we && !lat_we) |=> drive_en == ($past(wval) ? lat_q : '0));
endmodule

// File: rtl/io16_cmd_ctrl.sv
module io16_cmd_ctrl #(
  parameter int NPORTS = 16,
  parameter int ADDR_W = 6,
  parameter logic [3:0] DEV_ID = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_bus,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  input  logic              acc_bit,
  input  logic [NPORTS-1:0] pin_in,
  output logic [NPORTS-1:0] pin_out,
  output logic [NPORTS-1:0] pin_oe,
  output logic              rsp_valid,
  output logic              rsp_data
);
  import io16_pkg::*;
  localparam int IDX_W = $clog2(NPORTS);

  iocmd_t           cmd;
  logic             hit;
  logic [IDX_W-1:0] port_q;
  logic             sel_port;

  always_comb cmd = iocmd_t'(cmd_byte);
  always_comb sel_port = cmd.op[OP_SEL_BIT];

  io16_id_match #(.ID_W(ID_W), .DEV_ID(DEV_ID)) u_match (
    .valid(cmd_valid), .id(cmd.dev), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         port_q <= '0;
    else if (addr_load) port_q <= addr_bus[IDX_W-1:0];
  end

  io16_port_bank #(.NPORTS(NPORTS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .gate_we(hit && !sel_port), .lat_we(hit && sel_port),
    .idx(port_q), .wval(acc_bit),
    .lat_q(pin_out), .drive_en(pin_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 1'b0;
    end else begin
      rsp_valid <= hit;
      if (hit) rsp_data <= pin_in[port_q];
    end
  end

  // R2: foreign ID leaves outputs and response untouched
  a_r2_mismatch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd.dev != DEV_ID) |=> ($stable(pin_out) && $stable(pin_oe) && !rsp_valid));
  // R8: response only after a command
  a_r8_rsp_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid));
  // R9: no command, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(pin_out) && $stable(pin_oe)));
  // R7: reset clears drive
  a_r7_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && !rsp_valid));
endmodule

// File: tb/io16_cmd_ctrl_tb.sv
module io16_cmd_ctrl_tb;
  localparam logic [3:0] ID = 4'h4;
  logic clk = 0, rst_n = 0, addr_load = 0, cmd_valid = 0, acc_bit = 0;
  logic [5:0] addr_bus = 0;
  logic [7:0] cmd_byte = 0;
  logic [15:0] pin_in = 0, pin_out, pin_oe;
  logic rsp_valid, rsp_data;
  int total = 0, bad = 0;
  logic exp_en = 0;
  logic [15:0] exp_lat = 0;

  always #2 clk = ~clk;

  io16_cmd_ctrl u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_pins(string req);
    chk(req, {16'h0, pin_out}, {16'h0, exp_lat});
    chk(req, {16'h0, pin_oe}, {16'h0, exp_lat & {16{exp_en}}});
  endtask

  task automatic load_port(logic [5:0] a);
    @(negedge clk); addr_load = 1; addr_bus = a;
    @(negedge clk); addr_load = 0;
  endtask

  // drives one command cycle, returns at the negedge after it
  task automatic send(logic [3:0] id, logic [3:0] op, logic acc);
    @(negedge clk); cmd_valid = 1; cmd_byte = {id, op}; acc_bit = acc;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
    exp_en = 0; exp_lat = 0;
    chk("R7 reset pins", {pin_out, pin_oe}, 32'h0);
    chk("R7 reset rsp", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic t_port_writes;
    load_port(6'd0);  send(ID, 4'h1, 1); exp_lat[0] = 1;  chk_pins("R5 port0 set, gate off");
    load_port(6'd15); send(ID, 4'h1, 1); exp_lat[15] = 1; chk_pins("R5 port15 set");
    load_port(6'd7);  send(ID, 4'h3, 1); exp_lat[7] = 1;  chk_pins("R1 op bit0 selects port cmd");
    send(ID, 4'h0, 1); exp_en = 1; chk_pins("R4 enable on");
    chk("R6 oe", {16'h0, pin_oe}, 32'h8081);
    load_port(6'd0);  send(ID, 4'h1, 0); exp_lat[0] = 0;  chk_pins("R5 port0 clear");
    send(ID, 4'hE, 0); exp_en = 0; chk_pins("R1 op bit0 low is enable cmd, off");
  endtask

  task automatic t_mismatch;
    load_port(6'd3);
    send(ID ^ 4'h8, 4'h1, 1); chk_pins("R2 top bit differs");
    chk("R2 no rsp", {31'h0, rsp_valid}, 32'h0);
    send(ID ^ 4'h1, 4'h0, 1); chk_pins("R2 bottom bit differs");
    send(4'h0, 4'h1, 1); chk_pins("R2 other legal strap");
  endtask

  task automatic t_addr_bits;
    load_port(6'h35); // high bits 11, port 5
    send(ID, 4'h1, 1); exp_lat[5] = 1; chk_pins("R3 addr bits 5..4 ignored");
    @(negedge clk); addr_load = 1; addr_bus = 6'd9;
    @(negedge clk); addr_bus = 6'd10;
    @(negedge clk); addr_load = 0;
    send(ID, 4'h1, 1); exp_lat[10] = 1; chk_pins("R3 latest capture used");
  endtask

  task automatic t_readback;
    load_port(6'd6);
    pin_in = 16'hFFBF; // port6 low, neighbours high
    @(negedge clk); cmd_valid = 1; cmd_byte = {ID, 4'h0}; acc_bit = exp_en;
    @(negedge clk); cmd_valid = 0; pin_in = 16'hFFFF;
    chk("R8 rsp valid", {31'h0, rsp_valid}, 32'h1);
    chk("R8 rsp data low", {31'h0, rsp_data}, 32'h0);
    @(negedge clk);
    chk("R8 rsp one cycle", {31'h0, rsp_valid}, 32'h0);
    pin_in = 16'h0040;
    send(ID, 4'h0, exp_en);
    chk("R8 rsp data high", {31'h0, rsp_data}, 32'h1);
  endtask

  task automatic t_hold;
    send(ID, 4'h0, 1); exp_en = 1;
    repeat (5) @(negedge clk);
    chk_pins("R9 hold without cmd");
    rst_n = 0; @(negedge clk); rst_n = 1; exp_en = 0; exp_lat = 0;
    chk_pins("R7 reset clears latches");
  endtask

  initial begin
    fork
      begin
        t_reset(); t_port_writes(); t_mismatch(); t_addr_bits(); t_readback(); t_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule